// File: doc/BRIEF.md
# Host-Port Control and Interrupt Request Logic

This block sits on the processor side of a host interface port. The processor core writes and reads one control register. The register holds three interrupt enables, three flags that the core passes to the external host, and a bit that drives the host interrupt pin. The block combines the enables with three status inputs from the rest of the port: host command pending, transmit data request and receive data request. From these it produces registered interrupt request levels for the core.

A host command request is vectored. It carries the 7-bit vector that the host supplied, and a host-side non-maskable bit can force it regardless of its enable. Flags also pass from the host to the core and are mirrored one clock later. The flags never raise an interrupt, so software must poll them. The host interrupt pin is open-drain: it is brought out as an output enable and a data bit, and the data bit is always low.

Top module: `hostport_ctl`

## Requirements
- R1: While the hardware reset is active, and after it is released, the control register reads 0x00. All request outputs are 0, `flags_to_host` is 0 and `hint_oe` is 0 until the first write.
- R2: With `host_nmi` low, `irq_cmd` is 1 in the cycle after a clock edge at which control bit 0 and `cmd_pending` were both 1, and is 0 otherwise.
- R3: With `host_nmi` high, `irq_cmd` follows `cmd_pending` one clock later whatever the value of control bit 0.
- R4: While `irq_cmd` is 1, `irq_cmd_vec` equals the `host_vec` that was sampled at the same edge. While `irq_cmd` is 0, `irq_cmd_vec` is 0.
- R5: `irq_tx` is 1 one clock after an edge where control bit 1 and `tx_req` were both 1, and is 0 otherwise.
- R6: `irq_rx` is 1 one clock after an edge where control bit 2 and `rx_req` were both 1, and is 0 otherwise.
- R7: `flags_to_host[2:0]` equals control bits 5 to 3, with bit 3 as flag 0.
- R8: `flags_from_host` appears on `flags_to_core` one clock later. No flag, in either direction, changes any request output.
- R9: `hint_oe` equals control bit 6, and `hint_do` is always 0, so setting bit 6 pulls the pin low and clearing it releases the pin.
- R10: Control bit 7 always reads 0 whatever is written to it.
- R11: `sw_rst` clears the control register at the edge where it is sampled, even if a write is requested at that same edge. All request outputs are 0 in the following cycle.
- R12: A write with `reg_wr` high at one edge shows on `reg_rdata` right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| sw_rst | input | 1 | Synchronous software reset of the control state |
| reg_wr | input | 1 | Core write strobe for the control register |
| reg_wdata | input | 8 | Core write data |
| reg_rdata | output | 8 | Control register read value |
| cmd_pending | input | 1 | Host command pending status |
| host_nmi | input | 1 | Host non-maskable override for the command request |
| host_vec | input | 7 | Vector supplied by the host with its command |
| tx_req | input | 1 | Transmit data request status |
| rx_req | input | 1 | Receive data request status |
| flags_from_host | input | 3 | Flags written by the host |
| flags_to_core | output | 3 | Registered copy of the host flags for the core |
| flags_to_host | output | 3 | Core flags visible in the host status |
| irq_cmd | output | 1 | Host command interrupt request |
| irq_cmd_vec | output | 7 | Vector of the host command request |
| irq_tx | output | 1 | Transmit interrupt request |
| irq_rx | output | 1 | Receive interrupt request |
| hint_oe | output | 1 | Host interrupt pin output enable (drive when 1) |
| hint_do | output | 1 | Host interrupt pin data (always low) |

## Verification
The request logic is swept over all eight enable patterns, both override values and all eight status patterns, with a different vector for each case. Comparing these cases separates an enable that is ignored or applied to the wrong source from an override that leaks into the transmit and receive requests. All 256 write values are read back to expose bits that are dropped, stuck or swapped among the flags, the pin control and the reserved bit. The host-flag sweep runs with all enables clear and all status inputs raised, and shows whether any flag gates or creates a request. A software reset issued together with a write checks that reset has priority.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int CTRL_W    = 8;
  localparam int NSRC      = 3;
  localparam int NFLAG     = 3;
  localparam int VEC_W     = 7;
  localparam int B_EN_CMD  = 0;
  localparam int B_EN_TX   = 1;
  localparam int B_EN_RX   = 2;
  localparam int B_FLAG_LO = 3;
  localparam int B_HINT    = 6;
  localparam logic [CTRL_W-1:0] CTRL_MASK = 8'h7F;
endpackage

// File: rtl/hp_rst_sync.sv
module hp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic arst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign arst_n = sync_q[STAGES-1];
endmodule

// File: rtl/hp_ctrl_reg.sv
module hp_ctrl_reg #(
  parameter int                W    = 8,
  parameter logic [W-1:0]      MASK = '1
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         sw_rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;
  logic         q_en;

  always_comb begin
    q_en = sw_rst | wr;
    if (sw_rst) q_d = '0;
    else        q_d = wdata & MASK;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)   q <= '0;
    else if (q_en) q <= q_d;
  end
endmodule

// File: rtl/hp_irq_gen.sv
module hp_irq_gen #(
  parameter int NSRC  = 3,
  parameter int VEC_W = 7,
  parameter int NMI_SRC = 0
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             sw_rst,
  input  logic [NSRC-1:0]  en,
  input  logic [NSRC-1:0]  status,
  input  logic             nmi,
  input  logic [VEC_W-1:0] vec_in,
  output logic [NSRC-1:0]  req,
  output logic [VEC_W-1:0] vec_out
);
  logic [NSRC-1:0]  req_d;
  logic [VEC_W-1:0] vec_d;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (i == NMI_SRC) begin : g_nmi
      always_comb req_d[i] = !sw_rst && status[i] && (en[i] || nmi);
    end else begin : g_plain
      always_comb req_d[i] = !sw_rst && status[i] && en[i];
    end
  end

  always_comb vec_d = req_d[NMI_SRC] ? vec_in : '0;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      req     <= '0;
      vec_out <= '0;
    end else begin
      req     <= req_d;
      vec_out <= vec_d;
    end
  end
endmodule

// File: rtl/hp_flag_mirror.sv
module hp_flag_mirror #(
  parameter int NF = 3
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic [NF-1:0] din,
  output logic [NF-1:0] dout
);
  logic [NF-1:0] dout_d;

  always_comb dout_d = din;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) dout <= '0;
    else         dout <= dout_d;
  end
endmodule

// File: rtl/hostport_ctl.sv
module hostport_ctl
  import hp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_rst,
  input  logic             reg_wr,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [CTRL_W-1:0] reg_rdata,
  input  logic             cmd_pending,
  input  logic             host_nmi,
  input  logic [VEC_W-1:0] host_vec,
  input  logic             tx_req,
  input  logic             rx_req,
  input  logic [NFLAG-1:0] flags_from_host,
  output logic [NFLAG-1:0] flags_to_core,
  output logic [NFLAG-1:0] flags_to_host,
  output logic             irq_cmd,
  output logic [VEC_W-1:0] irq_cmd_vec,
  output logic             irq_tx,
  output logic             irq_rx,
  output logic             hint_oe,
  output logic             hint_do
);
  logic              arst_n;
  logic [CTRL_W-1:0] ctrl_q;
  logic [NSRC-1:0]   en_v;
  logic [NSRC-1:0]   stat_v;
  logic [NSRC-1:0]   req_v;

  hp_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .arst_n(arst_n)
  );

  hp_ctrl_reg #(.W(CTRL_W), .MASK(CTRL_MASK)) u_reg (
    .clk(clk), .arst_n(arst_n), .sw_rst(sw_rst),
    .wr(reg_wr), .wdata(reg_wdata), .q(ctrl_q)
  );

  always_comb begin
    en_v[B_EN_CMD] = ctrl_q[B_EN_CMD];
    en_v[B_EN_TX]  = ctrl_q[B_EN_TX];
    en_v[B_EN_RX]  = ctrl_q[B_EN_RX];
    stat_v         = {rx_req, tx_req, cmd_pending};
  end

  hp_irq_gen #(.NSRC(NSRC), .VEC_W(VEC_W), .NMI_SRC(B_EN_CMD)) u_irq (
    .clk(clk), .arst_n(arst_n), .sw_rst(sw_rst),
    .en(en_v), .status(stat_v), .nmi(host_nmi), .vec_in(host_vec),
    .req(req_v), .vec_out(irq_cmd_vec)
  );

  hp_flag_mirror #(.NF(NFLAG)) u_flag (
    .clk(clk), .arst_n(arst_n), .din(flags_from_host), .dout(flags_to_core)
  );

  assign reg_rdata     = ctrl_q;
  assign irq_cmd       = req_v[B_EN_CMD];
  assign irq_tx        = req_v[B_EN_TX];
  assign irq_rx        = req_v[B_EN_RX];
  assign flags_to_host = ctrl_q[B_FLAG_LO +: NFLAG];
  assign hint_oe       = ctrl_q[B_HINT];
  assign hint_do       = 1'b0;
endmodule

// File: rtl/hostport_ctl_checker.sv
module hostport_ctl_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sw_rst,
  input logic [7:0] reg_rdata,
  input logic       cmd_pending,
  input logic       host_nmi,
  input logic [6:0] host_vec,
  input logic       tx_req,
  input logic       rx_req,
  input logic [2:0] flags_to_host,
  input logic       irq_cmd,
  input logic [6:0] irq_cmd_vec,
  input logic       irq_tx,
  input logic       irq_rx,
  input logic       hint_oe,
  input logic       hint_do
);
  // R2 / R3
  a_r2_cmd_req: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cmd == $past(!sw_rst && cmd_pending && (reg_rdata[0] || host_nmi)));
  // R4
  a_r4_vec_on: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cmd |-> irq_cmd_vec == $past(host_vec));
  a_r4_vec_off: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_cmd |-> irq_cmd_vec == 7'd0);
  // R5
  a_r5_tx_req: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx == $past(!sw_rst && tx_req && reg_rdata[1]));
  // R6
  a_r6_rx_req: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx == $past(!sw_rst && rx_req && reg_rdata[2]));
  // R7
  a_r7_flags_out: assert property (@(posedge clk) disable iff (!rst_n)
    flags_to_host == reg_rdata[5:3]);
  // R9
  a_r9_pin: assert property (@(posedge clk) disable iff (!rst_n)
    !hint_do && (hint_oe == reg_rdata[6]));
  // R10
  a_r10_bit7: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[7]);
  // R11
  a_r11_swrst: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (reg_rdata == 8'd0) && !irq_cmd && !irq_tx && !irq_rx);
endmodule

bind hostport_ctl hostport_ctl_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .reg_rdata(reg_rdata),
  .cmd_pending(cmd_pending), .host_nmi(host_nmi), .host_vec(host_vec),
  .tx_req(tx_req), .rx_req(rx_req), .flags_to_host(flags_to_host),
  .irq_cmd(irq_cmd), .irq_cmd_vec(irq_cmd_vec), .irq_tx(irq_tx),
  .irq_rx(irq_rx), .hint_oe(hint_oe), .hint_do(hint_do)
);

// File: tb/hostport_ctl_test.sv
`timescale 1ns/1ps
module hostport_ctl_test;
  logic       clk = 1'b0;
  logic       rst_n, sw_rst, reg_wr, cmd_pending, host_nmi, tx_req, rx_req;
  logic [7:0] reg_wdata, reg_rdata;
  logic [6:0] host_vec, irq_cmd_vec;
  logic [2:0] flags_from_host, flags_to_core, flags_to_host;
  logic       irq_cmd, irq_tx, irq_rx, hint_oe, hint_do;
  int         n_run = 0;
  int         n_fail = 0;
  logic       done = 1'b0;

  always #2.5 clk = ~clk;

  hostport_ctl uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] v);
    reg_wr = 1'b1; reg_wdata = v; step(); reg_wr = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sw_rst = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    cmd_pending = 1'b0; host_nmi = 1'b0; host_vec = '0;
    tx_req = 1'b0; rx_req = 1'b0; flags_from_host = '0;
    step(); step();
    // R1 during reset
    check("R1 rdata", reg_rdata, 0);
    check("R1 irqs", {irq_cmd, irq_tx, irq_rx}, 0);
    check("R1 pin", {hint_oe, flags_to_host}, 0);
    rst_n = 1'b1;
    step(); step(); step();
    check("R1 after release", {reg_rdata, irq_cmd, irq_tx, irq_rx, hint_oe}, 0);

    // R12 / R10 / R7 / R9: sweep all write values
    for (int v = 0; v < 256; v++) begin
      wr(8'(v));
      check("R12 R10 readback", reg_rdata, v & 8'h7F);
      check("R7 flags_to_host", flags_to_host, (v >> 3) & 7);
      check("R9 hint", {hint_oe, hint_do}, {((v >> 6) & 1) != 0, 1'b0});
    end

    // R2 R3 R4 R5 R6: enables x nmi x status patterns
    for (int e = 0; e < 8; e++) begin
      for (int s = 0; s < 16; s++) begin
        logic [6:0] vec;
        logic ecmd, etx, erx;
        vec = 7'((e * 16 + s) * 5 + 3);
        wr(8'(e));
        host_nmi = s[3]; cmd_pending = s[0]; tx_req = s[1]; rx_req = s[2];
        host_vec = vec;
        step();
        ecmd = s[0] && (e[0] || s[3]);
        etx  = s[1] && e[1];
        erx  = s[2] && e[2];
        check(s[3] ? "R3 irq_cmd nmi" : "R2 irq_cmd", irq_cmd, ecmd);
        check("R4 irq_cmd_vec", irq_cmd_vec, ecmd ? vec : 7'd0);
        check("R5 irq_tx", irq_tx, etx);
        check("R6 irq_rx", irq_rx, erx);
      end
    end

    // R8: host flags mirrored, never raise requests
    wr(8'h38);
    cmd_pending = 1'b1; tx_req = 1'b1; rx_req = 1'b1; host_nmi = 1'b0;
    for (int f = 0; f < 8; f++) begin
      flags_from_host = 3'(f);
      step();
      check("R8 flags_to_core", flags_to_core, f);
      check("R8 no irq from flags", {irq_cmd, irq_tx, irq_rx}, 0);
    end

    // R11: software reset beats a write at the same edge
    wr(8'h7F);
    step();
    check("R11 pre irqs set", {irq_cmd, irq_tx, irq_rx}, 3'b111);
    sw_rst = 1'b1; reg_wr = 1'b1; reg_wdata = 8'h7F;
    step();
    sw_rst = 1'b0; reg_wr = 1'b0;
    check("R11 ctrl cleared", reg_rdata, 0);
    check("R11 irqs cleared", {irq_cmd, irq_tx, irq_rx}, 0);
    check("R11 pin released", hint_oe, 0);
    step();
    check("R11 irqs stay low", {irq_cmd, irq_tx, irq_rx}, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule